// File: doc/BRIEF.md
# Branch Direction History Table

This block predicts whether a conditional branch will be taken. It holds one small piece of direction state per table entry, and the entries carry no tags. The fetch stage presents the current program counter. In the same cycle the block returns a taken or not-taken guess, together with the table index that produced the guess. The fetch stage keeps that index alongside the instruction. Once decode has resolved the branch, it sends the index back with the real outcome, and the entry is trained on the next clock edge.

A build-time parameter selects how much state each entry holds. In single-bit mode an entry simply remembers the last outcome. In counter mode an entry is a two-bit saturating counter that needs two wrong guesses in a row before the guess changes. For a loop that closes with a backward branch, counter mode misses one time fewer on every pass of the loop. The block does not produce target addresses, flush the pipeline or record global history.

Top module: `branch_history_predictor`

## Requirements
- R1: The table index is program-counter bits [IDX_W+1:2], where IDX_W = log2(ENTRY_COUNT). Bits [1:0] and every bit above IDX_W+1 have no effect. Two addresses with equal index bits therefore read the same entry and train the same entry. The index is driven on `pred_index`.
- R2: After reset, every entry predicts not taken. In counter mode each entry starts in the weakly not-taken state 01, so a single taken update turns its prediction to taken.
- R3: In single-bit mode (TWO_BIT=0), an update stores the resolved outcome in the entry, 1 for taken. A wrong guess therefore inverts the bit, and a correct guess leaves it as it was.
- R4: In counter mode (TWO_BIT=1), the states are encoded 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. `pred_taken` is the most significant bit. A taken update moves the counter up by one state and a not-taken update moves it down by one state.
- R5: In counter mode the counter saturates. A taken update leaves state 11 at 11, and a not-taken update leaves state 00 at 00.
- R6: In counter mode, starting from a strong state, one opposite outcome does not change the prediction, and a second consecutive opposite outcome does change it.
- R7: An update takes effect at the clock edge. A read of the same entry in the update cycle returns the old prediction, and a read in the following cycle returns the new one. The prediction output is combinational from the current PC.
- R8: When `upd_valid` is low, no entry changes. When it is high, only the entry at `upd_index` changes.
- R9: Take a loop branch that is taken nine times and then not taken once, and run it repeatedly. After the first pass, single-bit mode mispredicts twice per pass and counter mode mispredicts once per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_WIDTH | Address of the instruction being fetched |
| pred_taken | output | 1 | Direction guess for `fetch_pc`, 1 = taken |
| pred_index | output | IDX_W | Table index used for the guess, kept by fetch for the later update |
| upd_valid | input | 1 | A resolved branch outcome is present this cycle |
| upd_index | input | IDX_W | Index captured when the branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
`pred_index` and `pred_taken` are combinational, so they are due in the same cycle that `fetch_pc` is driven. An update becomes visible only after the next rising edge. The bench drives inputs on the falling edge and samples the outputs 1 ns later. At that point it compares them against a reference model that has not yet applied the update for that cycle. It then applies the update to the model, so that the model advances at exactly the edge where the design does. The loop-count checks use the same timing: each pass is counted from the guess sampled just before its own update edge.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // Two-bit direction counter states; the MSB is the prediction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WEAK_NT;
    localparam logic       BIT_RESET = 1'b0;

    // Saturating step of a direction counter.
    function automatic ctr_state_e ctr_step(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_state_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_state_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_predict(input ctr_state_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bht_index_calc.sv
module bht_index_calc #(
    parameter int PC_WIDTH = 32,
    parameter int IDX_W    = 4
) (
    input  logic [PC_WIDTH-1:0] pc,
    output logic [IDX_W-1:0]    index
);
    localparam int LO_BIT = 2;
    localparam int HI_BIT = LO_BIT + IDX_W - 1;

    // Instruction alignment bits are dropped; high bits are discarded (aliasing).
    assign index = pc[HI_BIT:LO_BIT];
endmodule

// File: rtl/bht_entry.sv
module bht_entry
    import bht_pkg::*;
#(
    parameter bit TWO_BIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic taken,
    output logic predict
);
    generate
        if (TWO_BIT) begin : g_counter
            ctr_state_e state;

            always_ff @(posedge clk) begin
                if (rst)      state <= CTR_RESET;
                else if (hit) state <= ctr_step(state, taken);
            end

            assign predict = ctr_predict(state);

            assert_sat_high_R5: assert property (@(posedge clk) disable iff (rst)
                (state == CTR_STRONG_T && hit && taken) |=> state == CTR_STRONG_T);
            assert_sat_low_R5: assert property (@(posedge clk) disable iff (rst)
                (state == CTR_STRONG_NT && hit && !taken) |=> state == CTR_STRONG_NT);
            assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !hit |=> $stable(state));
            assert_step_R4: assert property (@(posedge clk) disable iff (rst)
                hit |=> (state != $past(state)) ||
                        ($past(state) == CTR_STRONG_T) || ($past(state) == CTR_STRONG_NT));
            assert_hyst_taken_R6: assert property (@(posedge clk) disable iff (rst)
                (state == CTR_STRONG_T && hit && !taken) |=> predict);
            assert_hyst_ntaken_R6: assert property (@(posedge clk) disable iff (rst)
                (state == CTR_STRONG_NT && hit && taken) |=> !predict);
        end else begin : g_single
            logic last_dir;

            always_ff @(posedge clk) begin
                if (rst)      last_dir <= BIT_RESET;
                else if (hit) last_dir <= taken;
            end

            assign predict = last_dir;

            assert_last_outcome_R3: assert property (@(posedge clk) disable iff (rst)
                hit |=> predict == $past(taken));
            assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !hit |=> $stable(predict));
        end
    endgenerate
endmodule

// File: rtl/bht_read_mux.sv
module bht_read_mux #(
    parameter int ENTRY_COUNT = 16,
    parameter int IDX_W       = 4
) (
    input  logic [ENTRY_COUNT-1:0] entry_pred,
    input  logic [IDX_W-1:0]       sel,
    output logic                   pred
);
    assign pred = entry_pred[sel];
endmodule

// File: rtl/branch_history_predictor.sv
module branch_history_predictor
    import bht_pkg::*;
#(
    parameter int ENTRY_COUNT = 16,
    parameter bit TWO_BIT     = 1'b1,
    parameter int PC_WIDTH    = 32,
    localparam int IDX_W      = $clog2(ENTRY_COUNT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PC_WIDTH-1:0] fetch_pc,
    output logic                pred_taken,
    output logic [IDX_W-1:0]    pred_index,
    input  logic                upd_valid,
    input  logic [IDX_W-1:0]    upd_index,
    input  logic                upd_taken
);
    logic [ENTRY_COUNT-1:0] entry_pred;
    logic [ENTRY_COUNT-1:0] entry_hit;

    bht_index_calc #(.PC_WIDTH(PC_WIDTH), .IDX_W(IDX_W)) u_index (
        .pc    (fetch_pc),
        .index (pred_index)
    );

    // Update decoder: exactly one entry selected when an update is present.
    always_comb begin
        entry_hit = '0;
        if (upd_valid) entry_hit[upd_index] = 1'b1;
    end

    generate
        for (genvar e = 0; e < ENTRY_COUNT; e++) begin : g_entry
            bht_entry #(.TWO_BIT(TWO_BIT)) u_entry (
                .clk     (clk),
                .rst     (rst),
                .hit     (entry_hit[e]),
                .taken   (upd_taken),
                .predict (entry_pred[e])
            );
        end
    endgenerate

    bht_read_mux #(.ENTRY_COUNT(ENTRY_COUNT), .IDX_W(IDX_W)) u_mux (
        .entry_pred (entry_pred),
        .sel        (pred_index),
        .pred       (pred_taken)
    );

    assert_one_update_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(entry_hit) && (upd_valid == (entry_hit != '0)));
    assert_reset_nt_R2: assert property (@(posedge clk)
        $past(rst) |-> entry_pred == '0);
endmodule

// File: tb/tb_branch_history_predictor.sv
module tb_branch_history_predictor;
    localparam int CLK_P = 10;
    localparam int N     = 16;
    localparam int IW    = 4;

    logic clk = 1'b0;
    logic rst;
    logic [31:0] pc;
    logic uv, ut;
    logic [IW-1:0] ui;
    logic p2, p1;
    logic [IW-1:0] i2, i1;

    int errors = 0;
    int checks = 0;
    int m2 [N];
    int m1 [N];

    always #(CLK_P/2) clk = ~clk;

    branch_history_predictor #(.ENTRY_COUNT(N), .TWO_BIT(1'b1), .PC_WIDTH(32)) dut (
        .clk(clk), .rst(rst), .fetch_pc(pc), .pred_taken(p2), .pred_index(i2),
        .upd_valid(uv), .upd_index(ui), .upd_taken(ut));

    branch_history_predictor #(.ENTRY_COUNT(N), .TWO_BIT(1'b0), .PC_WIDTH(32)) dut_onebit (
        .clk(clk), .rst(rst), .fetch_pc(pc), .pred_taken(p1), .pred_index(i1),
        .upd_valid(uv), .upd_index(ui), .upd_taken(ut));

    function automatic int ctr_next(int s, bit t);
        if (t) return (s == 3) ? 3 : s + 1;
        return (s == 0) ? 0 : s - 1;
    endfunction

    function automatic int exp_index(logic [31:0] a);
        return int'(a[5:2]);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < N; k++) begin
            m2[k] = 1;
            m1[k] = 0;
        end
    endtask

    // Drive at negedge, sample 1 ns later, then advance the model for the coming edge.
    task automatic cyc(logic [31:0] a, bit v, int idx, bit t, bit chk);
        @(negedge clk);
        pc = a; uv = v; ui = IW'(idx); ut = t;
        #1;
        if (chk) begin
            check("R1 index", int'(i2), exp_index(a));
            check("R1 index onebit", int'(i1), exp_index(a));
            check("R4 counter predict", int'(p2), m2[exp_index(a)] >> 1);
            check("R3 single-bit predict", int'(p1), m1[exp_index(a)]);
        end
        if (v) begin
            m2[idx] = ctr_next(m2[idx], t);
            m1[idx] = int'(t);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dummy;
        int miss2, miss1;
        logic [31:0] lp;
        dummy = $urandom(32'd1234);
        rst = 1'b1; pc = '0; uv = 1'b0; ui = '0; ut = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2: every entry predicts not taken after reset
        for (int k = 0; k < N; k++) begin
            cyc(32'(k << 2), 1'b0, 0, 1'b0, 1'b0);
            check("R2 reset counter", int'(p2), 0);
            check("R2 reset single", int'(p1), 0);
        end

        // R2/R7: one taken update on entry 3; same-cycle read is old, next is new
        cyc(32'h0000_000C, 1'b1, 3, 1'b1, 1'b0);
        check("R7 same-cycle old", int'(p2), 0);
        cyc(32'h0000_000C, 1'b0, 0, 1'b0, 1'b0);
        check("R2 weak start flips", int'(p2), 1);
        check("R7 next-cycle new", int'(p1), 1);

        // R1: aliasing via upper bits and low alignment bits
        cyc(32'hABCD_004F, 1'b0, 0, 1'b0, 1'b0);
        check("R1 alias predict", int'(p2), 1);
        check("R1 alias index", int'(i2), 3);

        // R5/R6: drive entry 5 to strong taken, saturate, then two not-taken
        for (int k = 0; k < 4; k++) cyc(32'h14, 1'b1, 5, 1'b1, 1'b1);
        cyc(32'h14, 1'b1, 5, 1'b0, 1'b0);
        cyc(32'h14, 1'b0, 0, 1'b0, 1'b0);
        check("R6 one miss keeps taken", int'(p2), 1);
        check("R3 single flips on miss", int'(p1), 0);
        cyc(32'h14, 1'b1, 5, 1'b0, 1'b0);
        cyc(32'h14, 1'b0, 0, 1'b0, 1'b0);
        check("R6 second miss flips", int'(p2), 0);
        for (int k = 0; k < 3; k++) cyc(32'h14, 1'b1, 5, 1'b0, 1'b1);
        cyc(32'h14, 1'b1, 5, 1'b1, 1'b0);
        cyc(32'h14, 1'b0, 0, 1'b0, 1'b0);
        check("R5 low saturation", int'(p2), 0);

        // R8: update to entry 7 leaves entry 6 unchanged
        cyc(32'h18, 1'b1, 7, 1'b1, 1'b1);
        cyc(32'h18, 1'b1, 7, 1'b1, 1'b1);
        cyc(32'h18, 1'b0, 0, 1'b0, 1'b0);
        check("R8 neighbour untouched", int'(p2), 0);
        check("R8 neighbour untouched onebit", int'(p1), 0);

        // R9: 9 taken + 1 not taken loop, three passes, count misses on passes 2 and 3
        lp = 32'h0000_0020;
        for (int pass = 0; pass < 3; pass++) begin
            miss2 = 0; miss1 = 0;
            for (int it = 0; it < 10; it++) begin
                bit t;
                t = (it != 9);
                cyc(lp, 1'b1, exp_index(lp), t, 1'b0);
                if (p2 != t) miss2++;
                if (p1 != t) miss1++;
            end
            if (pass > 0) begin
                check("R9 counter misses per pass", miss2, 1);
                check("R9 single-bit misses per pass", miss1, 2);
            end
        end

        // Random traffic against the models (R1 R3 R4 R5 R7 R8)
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] a;
            a = $urandom;
            cyc(a, ($urandom % 3) != 0, int'($urandom % N), ($urandom % 4) != 0, 1'b1);
        end

        // R2: reset mid-run returns all entries to not taken
        @(negedge clk); rst = 1'b1; uv = 1'b0;
        @(negedge clk); rst = 1'b0;
        model_reset();
        for (int k = 0; k < N; k++) cyc(32'(k << 2), 1'b0, 0, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule